// File: doc/BRIEF.md
# Edge-Window Pulse Counter

The block counts edges of one chosen polarity on an asynchronous input pin during a measurement window whose length is a number of timebase ticks. When the window closes, the number of edges seen is placed in a result register and a done flag is raised. Software then divides that count by the window length to get the frequency. The division is not part of this block.

A 2-bit sequence code selects the edge polarity and whether measurement stops after one window or runs on. A 2-bit service code starts the channel. The sequence code and the window size are taken at that moment and held until the next start. In continuous operation the next window starts at once, and no edge is lost across the boundary.

Top module: `freq_window_meas`

## Requirements
- R1: After reset, result_o is 0 and done_o is 0. Until a start request arrives, ticks and pin edges leave both outputs unchanged.
- R2: When bit 1 of the captured sequence code is 1, each rising edge of pin_i adds one to the count and falling edges are ignored.
- R3: When bit 1 of the captured sequence code is 0, each falling edge of pin_i adds one to the count and rising edges are ignored.
- R4: A window closes on the Nth cycle with tick_i high after the start, where N is the captured window size (a size of 0 means 65536). On that clock edge result_o takes the window's count and done_o goes to 1. result_o changes at no other time.
- R5: When bit 0 of the captured sequence code is 0 (single-shot), the channel stops after one window. Later ticks and edges leave result_o and done_o unchanged until the next start.
- R6: When bit 0 of the captured sequence code is 1 (continuous), a new window with a zero count begins right after each window closes. Each window's count appears at that window's close.
- R7: An edge detected in the same cycle as the closing tick is counted in the next window, not in the closing one.
- R8: svc_req_i = 2'b10 starts the channel: the count and window position are cleared and done_o reads 0 on the next cycle. The codes 2'b00, 2'b01 and 2'b11 have no effect.
- R9: seq_mode_i and win_size_i are sampled only at a start request. Changes made while measuring do not affect the window in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase tick enable; one cycle high per tick |
| pin_i | input | 1 | Asynchronous input being measured |
| seq_mode_i | input | 2 | Bit 1: 1 = rising, 0 = falling edges; bit 0: 1 = continuous, 0 = single-shot |
| svc_req_i | input | 2 | Service code; 2'b10 starts the channel, others are no request |
| win_size_i | input | 16 | Window length in ticks |
| result_o | output | 16 | Edge count of the last closed window |
| done_o | output | 1 | Set when a window closes; cleared by a start |

## Verification
A window counter that is off by one shows at the ports as done_o rising one tick early or late. The bench checks this on the exact tick where the window should close. A count that slips or loses an edge at the window boundary shows in the result of the window that closes next, which is at most one window later. The case where an edge lands on the closing tick is driven deliberately. A run state that fails to stop in single-shot mode shows as result_o changing on a later window, and the bench watches for that across extra ticks after the window.

// File: rtl/freqm_pkg.sv
package freqm_pkg;
  typedef enum logic [1:0] {
    SVC_NONE = 2'b00,
    SVC_RSV1 = 2'b01,
    SVC_INIT = 2'b10,
    SVC_RSV3 = 2'b11
  } svc_e;

  localparam int unsigned MODE_RISE_BIT = 1;
  localparam int unsigned MODE_CONT_BIT = 0;
endpackage

// File: rtl/freqm_sync_edge.sv
module freqm_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[i] <= 1'b0;
        else         sync_q[i] <= pin_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[i] <= 1'b0;
        else         sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/freqm_win_ctrl.sv
module freqm_win_ctrl #(
  parameter int unsigned WIN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             tick_i,
  input  logic             cont_i,
  input  logic [WIN_W-1:0] size_i,
  output logic             run_o,
  output logic             win_end_o,
  output logic [WIN_W-1:0] win_cnt_o
);
  logic [WIN_W-1:0] cnt_q;
  logic             run_q;
  logic             last_tick;

  // size 0 wraps to full range
  assign last_tick = (cnt_q == size_i - 1'b1);
  assign win_end_o = run_q && tick_i && last_tick && !init_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (init_i) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q && tick_i) begin
      if (last_tick) begin
        cnt_q <= '0;
        run_q <= cont_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign run_o     = run_q;
  assign win_cnt_o = cnt_q;
endmodule

// File: rtl/freqm_pulse_acc.sv
module freqm_pulse_acc #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             run_i,
  input  logic             win_end_i,
  input  logic             cont_i,
  input  logic             edge_i,
  output logic [CNT_W-1:0] result_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] res_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else if (init_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (win_end_i) begin
      res_q  <= cnt_q;
      done_q <= 1'b1;
      // boundary edge belongs to the next window
      cnt_q  <= (cont_i && edge_i) ? CNT_W'(1) : '0;
    end else if (run_i && edge_i) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign result_o = res_q;
  assign done_o   = done_q;
endmodule

// File: rtl/freq_window_meas.sv
module freq_window_meas
  import freqm_pkg::*;
#(
  parameter int unsigned WIN_W       = 16,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             pin_i,
  input  logic [1:0]       seq_mode_i,
  input  logic [1:0]       svc_req_i,
  input  logic [WIN_W-1:0] win_size_i,
  output logic [CNT_W-1:0] result_o,
  output logic             done_o
);
  logic             init;
  logic [1:0]       mode_q;
  logic [WIN_W-1:0] size_q;
  logic             rise, fall, sel_edge;
  logic             run_q, win_end;
  logic [WIN_W-1:0] win_cnt;

  assign init = (svc_req_i == SVC_INIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      size_q <= '0;
    end else if (init) begin
      mode_q <= seq_mode_i;
      size_q <= win_size_i;
    end
  end

  freqm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign sel_edge = mode_q[MODE_RISE_BIT] ? rise : fall;

  freqm_win_ctrl #(.WIN_W(WIN_W)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .init_i    (init),
    .tick_i    (tick_i),
    .cont_i    (mode_q[MODE_CONT_BIT]),
    .size_i    (size_q),
    .run_o     (run_q),
    .win_end_o (win_end),
    .win_cnt_o (win_cnt)
  );

  freqm_pulse_acc #(.CNT_W(CNT_W)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .init_i    (init),
    .run_i     (run_q),
    .win_end_i (win_end),
    .cont_i    (mode_q[MODE_CONT_BIT]),
    .edge_i    (sel_edge),
    .result_o  (result_o),
    .done_o    (done_o)
  );
endmodule

// File: rtl/freqm_checker.sv
module freqm_checker #(
  parameter int unsigned WIN_W = 16,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       svc_req_i,
  input logic [CNT_W-1:0] result_o,
  input logic             done_o,
  input logic             run_i,
  input logic             win_end_i,
  input logic             cont_i,
  input logic [WIN_W-1:0] win_cnt_i,
  input logic [WIN_W-1:0] size_i
);
  AST_INIT_CLEARS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_req_i == 2'b10 |=> !done_o); // R8

  AST_RESULT_ONLY_AT_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> done_o); // R4

  AST_WIN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> win_cnt_i <= size_i - 1'b1); // R4

  AST_IDLE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && svc_req_i != 2'b10) |=> ($stable(result_o) && $stable(done_o))); // R5

  AST_SINGLE_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_end_i && !cont_i) |=> !run_i); // R5

  AST_CONT_RUNS_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_end_i && cont_i) |=> run_i); // R6
endmodule

bind freq_window_meas freqm_checker #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .svc_req_i (svc_req_i),
  .result_o  (result_o),
  .done_o    (done_o),
  .run_i     (run_q),
  .win_end_i (win_end),
  .cont_i    (mode_q[0]),
  .win_cnt_i (win_cnt),
  .size_i    (size_q)
);

// File: tb/sim_freq_window_meas.sv
`timescale 1ns/1ps
module sim_freq_window_meas;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        pin_i = 1'b0;
  logic [1:0]  seq_mode_i = 2'b00;
  logic [1:0]  svc_req_i = 2'b00;
  logic [15:0] win_size_i = 16'd0;
  logic [15:0] result_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  freq_window_meas u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .pin_i(pin_i),
    .seq_mode_i(seq_mode_i), .svc_req_i(svc_req_i), .win_size_i(win_size_i),
    .result_o(result_o), .done_o(done_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i) pin_i = 1'b1;
      repeat (3) @(negedge clk_i);
      pin_i = 1'b0;
      repeat (3) @(negedge clk_i);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i) tick_i = 1'b1;
      @(negedge clk_i) tick_i = 1'b0;
    end
  endtask

  task automatic start(input logic [1:0] m, input logic [15:0] s);
    @(negedge clk_i);
    seq_mode_i = m; win_size_i = s; svc_req_i = 2'b10;
    @(negedge clk_i) svc_req_i = 2'b00;
  endtask

  task automatic t_reset;
    check("R1 result after reset", result_o, 0);
    check("R1 done after reset", done_o, 0);
    pulses(2);
    ticks(3);
    check("R1 idle done", done_o, 0);
    check("R1 idle result", result_o, 0);
  endtask

  task automatic t_rise_single;
    start(2'b10, 16'd5);
    check("R8 done cleared on start", done_o, 0);
    pulses(3);
    ticks(4);
    check("R4 no close before N ticks", done_o, 0);
    ticks(1);
    check("R4 done at Nth tick", done_o, 1);
    check("R2 rising count", result_o, 3);
  endtask

  task automatic t_single_stops;
    pulses(4);
    ticks(10);
    check("R5 result frozen", result_o, 3);
    check("R5 done held", done_o, 1);
  endtask

  task automatic t_svc_codes;
    @(negedge clk_i) svc_req_i = 2'b01;
    @(negedge clk_i) svc_req_i = 2'b11;
    @(negedge clk_i) svc_req_i = 2'b00;
    @(negedge clk_i);
    check("R8 other codes ignored done", done_o, 1);
    check("R8 other codes ignored result", result_o, 3);
  endtask

  task automatic t_fall;
    start(2'b00, 16'd3);
    check("R8 restart clears done", done_o, 0);
    pulses(2);
    @(negedge clk_i) pin_i = 1'b1;
    repeat (4) @(negedge clk_i);
    ticks(3);
    check("R3 falling count", result_o, 2);
    check("R4 done falling", done_o, 1);
    @(negedge clk_i) pin_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_continuous;
    start(2'b11, 16'd4);
    pulses(2);
    ticks(4);
    check("R6 first window", result_o, 2);
    pulses(5);
    ticks(4);
    check("R6 second window", result_o, 5);
    ticks(4);
    check("R6 empty window", result_o, 0);
  endtask

  task automatic t_boundary;
    start(2'b11, 16'd2);
    ticks(1);
    @(negedge clk_i) pin_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i) tick_i = 1'b1;   // rise detected on this closing tick
    @(negedge clk_i) tick_i = 1'b0;
    check("R7 closing window excludes edge", result_o, 0);
    repeat (3) @(negedge clk_i);
    pin_i = 1'b0;
    repeat (3) @(negedge clk_i);
    ticks(2);
    check("R7 edge in next window", result_o, 1);
  endtask

  task automatic t_capture;
    start(2'b10, 16'd3);
    @(negedge clk_i);
    seq_mode_i = 2'b01; win_size_i = 16'd100;
    pin_i = 1'b1;
    repeat (4) @(negedge clk_i);
    ticks(2);
    check("R9 size held, not early", done_o, 0);
    ticks(1);
    check("R9 size held, closes", done_o, 1);
    check("R9 polarity held", result_o, 1);
    @(negedge clk_i) pin_i = 1'b0;
    repeat (4) @(negedge clk_i);
    ticks(4);
    check("R9 single-shot held", result_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_rise_single();
    t_single_stops();
    t_svc_codes();
    t_fall();
    t_continuous();
    t_boundary();
    t_capture();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule